// File: doc/BRIEF.md
# Quad-line execute-in-place flash read controller

This block is the host-side engine for reading a serial NOR flash over a four-line SPI bus while the flash stays in execute-in-place (XIP) mode. A system-side request carries a 24-bit byte address, a byte count and an exit flag. The controller runs one chip-select-framed read for each request and returns the fetched bytes one per cycle on a valid strobe.

The first read after reset carries the quad fast read instruction 0xEB, sent one bit per clock on line 0. The controller then tracks whether the flash is in XIP mode. While it is, later reads leave out the instruction and begin directly with the address. In the first dummy clock of every read, line 0 carries a confirmation bit. A 0 keeps the flash in XIP mode. A 1 (requested through the exit flag) makes the flash leave it, and the next read then sends the full instruction again.

SCK is produced from the system clock by a divider and idles low (SPI mode 0). Chip select stays low for the whole read and is then held high for at least two SCK periods before the next read begins.

Top module: `qspi_xip_reader`

## Requirements
- R1: When `xip_active` is 0 at the moment a request is accepted, the read begins with 8 SCK clocks that carry the byte 0xEB on line 0, most significant bit first. During these clocks only line 0 is driven (`dq_oe` = 4'b0001) and lines 3..1 drive 0.
- R2: When `xip_active` is 1 at the moment a request is accepted, no instruction clocks are sent. The first SCK clock of the read already carries address bits 23..20.
- R3: The 24-bit address takes 6 SCK clocks, four bits per clock, highest nibble first, with bit 3 of each nibble on line 3. All four lines are driven (`dq_oe` = 4'hF).
- R4: `DUMMY_CLKS` dummy clocks follow the address (default 6, and at least 1 is required). All four lines stay driven. In the first dummy clock, line 0 carries `req_exit` as it was captured with the request, and lines 3..1 are 0. In every later dummy clock, all four lines are 0.
- R5: All output enables go low on the falling SCK edge that ends the last dummy clock. They stay low until chip select rises.
- R6: Each data byte takes two SCK clocks, high nibble first, and is sampled on the rising edge. `rd_valid` pulses once per byte, with `rd_data` holding the byte. Exactly `req_len_m1`+1 bytes are returned, from consecutive addresses that wrap modulo 2^24.
- R7: `xip_active` is 0 after reset. It is updated only in the cycle in which chip select rises at the end of a read, and it becomes the inverse of that read's confirmation bit.
- R8: A read whose confirmation bit was 1 is followed by a read that sends the full instruction again.
- R9: SCK is low whenever chip select is high. Each high and each low phase of SCK lasts `DIV` system clocks.
- R10: Between two reads, chip select stays high for at least 4×`DIV` system clocks (two SCK periods). `req_ready` is 1 only while no read is in progress and chip select is high.
- R11: After reset: `cs_n`=1, `sck`=0, `dq_oe`=0, `rd_valid`=0, `req_ready`=1, `xip_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, so a request is accepted this cycle |
| req_addr | input | 24 | Start byte address |
| req_len_m1 | input | LEN_W | Number of bytes minus one |
| req_exit | input | 1 | Send confirmation bit 1 so the flash leaves XIP mode |
| rd_valid | output | 1 | One-cycle strobe per returned byte |
| rd_data | output | 8 | Returned byte |
| xip_active | output | 1 | Flash is believed to be in XIP mode |
| sck | output | 1 | SPI clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| dq_out | output | 4 | Values driven on the four data lines |
| dq_oe | output | 4 | Per-line output enable |
| dq_in | input | 4 | Values read from the four data lines |

## Verification
Assertions check the framing rules on every cycle: SCK is low and all lines are released whenever chip select is high, SCK moves only on a divider tick, `xip_active` changes only as chip select rises, only line 0 is enabled during the instruction, and the bus is released while data is returned. The bench models the flash, and only its scenarios can show the rest. These are the instruction byte, the order of the address nibbles, the confirmation bit and the dummy-line values, and the data returned across address wrap. They also include the re-sent instruction after an exit and the measured chip-select gap and SCK phase widths.

// File: rtl/qxr_pkg.sv
`timescale 1ns/1ps
package qxr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    localparam logic [7:0] QUAD_FAST_READ = 8'hEB;
    localparam int ADDR_W      = 24;
    localparam int ADDR_NIBS   = ADDR_W / 4;
    localparam int GAP_HALVES  = 4;
endpackage

// File: rtl/qxr_tick.sv
`timescale 1ns/1ps
module qxr_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == CW'(DIV - 1));
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qxr_seq.sv
`timescale 1ns/1ps
module qxr_seq
    import qxr_pkg::*;
#(
    parameter int DUMMY_CLKS = 6,
    parameter int LEN_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic              run,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              req_exit,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              xip_active,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic [3:0]        dq_in
);
    localparam int BL_W  = LEN_W + 1;
    localparam int CMAX  = (DUMMY_CLKS > 8) ? DUMMY_CLKS : 8;
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic              sck;
        logic              cs_n;
        logic [3:0]        dqo;
        logic [3:0]        oe;
        logic [7:0]        cmd;
        logic [23:0]       addr;
        logic              conf;
        logic [BL_W-1:0]   left;
        logic [3:0]        hi;
        logic              vld;
        logic [7:0]        data;
        logic              xip;
    } st_t;

    localparam st_t RST = '{ph: PH_IDLE, cnt: '0, sck: 1'b0, cs_n: 1'b1,
                            dqo: 4'h0, oe: 4'h0, cmd: 8'h00, addr: 24'h0,
                            conf: 1'b0, left: '0, hi: 4'h0, vld: 1'b0,
                            data: 8'h00, xip: 1'b0};

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.vld   = 1'b0;
        req_ready = (s_q.ph == PH_IDLE);
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.cs_n = 1'b0;
                    s_d.sck  = 1'b0;
                    s_d.addr = req_addr;
                    s_d.cmd  = QUAD_FAST_READ;
                    s_d.conf = req_exit;
                    s_d.left = BL_W'(req_len_m1) + 1'b1;
                    if (s_q.xip) begin
                        s_d.ph  = PH_ADDR;
                        s_d.cnt = CNT_W'(ADDR_NIBS - 1);
                        s_d.dqo = req_addr[23:20];
                        s_d.oe  = 4'hF;
                    end else begin
                        s_d.ph  = PH_CMD;
                        s_d.cnt = CNT_W'(7);
                        s_d.dqo = {3'b000, QUAD_FAST_READ[7]};
                        s_d.oe  = 4'b0001;
                    end
                end
            end
            PH_GAP: begin
                if (tick) begin
                    if (s_q.cnt == '0) s_d.ph  = PH_IDLE;
                    else               s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                if (tick && !s_q.sck) begin
                    s_d.sck = 1'b1;
                    if (s_q.ph == PH_DATA) begin
                        if (s_q.cnt != '0) begin
                            s_d.hi  = dq_in;
                            s_d.cnt = '0;
                        end else begin
                            s_d.vld  = 1'b1;
                            s_d.data = {s_q.hi, dq_in};
                            s_d.cnt  = CNT_W'(1);
                            s_d.left = s_q.left - 1'b1;
                        end
                    end
                end else if (tick) begin
                    s_d.sck = 1'b0;
                    case (s_q.ph)
                        PH_CMD: begin
                            if (s_q.cnt == '0) begin
                                s_d.ph  = PH_ADDR;
                                s_d.cnt = CNT_W'(ADDR_NIBS - 1);
                                s_d.dqo = s_q.addr[23:20];
                                s_d.oe  = 4'hF;
                            end else begin
                                s_d.cnt = s_q.cnt - 1'b1;
                                s_d.cmd = {s_q.cmd[6:0], s_q.cmd[7]};
                                s_d.dqo = {3'b000, s_d.cmd[7]};
                            end
                        end
                        PH_ADDR: begin
                            if (s_q.cnt == '0) begin
                                s_d.ph  = PH_DUMMY;
                                s_d.cnt = CNT_W'(DUMMY_CLKS - 1);
                                s_d.dqo = {3'b000, s_q.conf};
                            end else begin
                                s_d.cnt  = s_q.cnt - 1'b1;
                                s_d.addr = {s_q.addr[19:0], s_q.addr[23:20]};
                                s_d.dqo  = s_d.addr[23:20];
                            end
                        end
                        PH_DUMMY: begin
                            s_d.dqo = 4'h0;
                            if (s_q.cnt == '0) begin
                                s_d.ph  = PH_DATA;
                                s_d.cnt = CNT_W'(1);
                                s_d.oe  = 4'h0;
                            end else begin
                                s_d.cnt = s_q.cnt - 1'b1;
                            end
                        end
                        PH_DATA: begin
                            if (s_q.left == '0) begin
                                s_d.ph   = PH_GAP;
                                s_d.cs_n = 1'b1;
                                s_d.cnt  = CNT_W'(GAP_HALVES - 1);
                                s_d.xip  = !s_q.conf;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST;
        else        s_q <= s_d;
    end

    assign run        = (s_q.ph != PH_IDLE);
    assign rd_valid   = s_q.vld;
    assign rd_data    = s_q.data;
    assign xip_active = s_q.xip;
    assign sck        = s_q.sck;
    assign cs_n       = s_q.cs_n;
    assign dq_out     = s_q.dqo;
    assign dq_oe      = s_q.oe;

    // R9
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck && dq_oe == 4'h0));

    // R9
    sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> $past(tick));

    // R7
    xip_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xip_active) |-> $rose(cs_n));

    // R5
    data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!cs_n && dq_oe == 4'h0));

    // R1
    cmd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_CMD) |-> (dq_oe == 4'b0001 && dq_out[3:1] == 3'b000));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !sck));
endmodule

// File: rtl/qspi_xip_reader.sv
`timescale 1ns/1ps
module qspi_xip_reader #(
    parameter int DIV        = 2,
    parameter int DUMMY_CLKS = 6,
    parameter int LEN_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              req_exit,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              xip_active,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic [3:0]        dq_in
);
    logic tick;
    logic run;

    qxr_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    qxr_seq #(.DUMMY_CLKS(DUMMY_CLKS), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .run        (run),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_len_m1 (req_len_m1),
        .req_exit   (req_exit),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .xip_active (xip_active),
        .sck        (sck),
        .cs_n       (cs_n),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .dq_in      (dq_in)
    );
endmodule

// File: tb/qspi_xip_reader_test.sv
`timescale 1ns/1ps
module qspi_xip_reader_test;
    localparam int DIV = 2;
    localparam int DUM = 6;
    localparam int LW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [23:0]   req_addr = '0;
    logic [LW-1:0] req_len_m1 = '0;
    logic          req_exit = 1'b0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          xip_active;
    logic          sck, cs_n;
    logic [3:0]    dq_out, dq_oe, dq_in;
    logic          fl_oe = 1'b0;
    logic [3:0]    fl_d = 4'h0;

    assign dq_in = fl_oe ? fl_d : 4'h0;

    qspi_xip_reader #(.DIV(DIV), .DUMMY_CLKS(DUM), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .req_exit(req_exit),
        .rd_valid(rd_valid), .rd_data(rd_data), .xip_active(xip_active),
        .sck(sck), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
    endfunction

    // flash model state and per-read observations
    bit          fl_xip = 0;
    bit          m_had_cmd;
    logic [7:0]  m_cmd;
    logic [23:0] m_addr;
    logic        m_conf;
    bit          m_dummy_bad, m_oe_bad, m_rel_bad;

    initial begin
        forever begin
            @(negedge cs_n);
            #1;
            m_had_cmd = 0; m_cmd = 8'h00; m_addr = '0; m_conf = 1'b0;
            m_dummy_bad = 0; m_oe_bad = 0; m_rel_bad = 0;
            if (!fl_xip) begin
                m_had_cmd = 1;
                for (int i = 0; i < 8; i++) begin
                    @(posedge sck); #1;
                    m_cmd = {m_cmd[6:0], dq_out[0]};
                    if (dq_oe != 4'b0001 || dq_out[3:1] != 3'b000) m_oe_bad = 1;
                end
            end
            for (int i = 0; i < 6; i++) begin
                @(posedge sck); #1;
                m_addr = {m_addr[19:0], dq_out};
                if (dq_oe != 4'hF) m_oe_bad = 1;
            end
            for (int i = 0; i < DUM; i++) begin
                @(posedge sck); #1;
                if (dq_oe != 4'hF) m_oe_bad = 1;
                if (i == 0) begin
                    m_conf = dq_out[0];
                    if (dq_out[3:1] != 3'b000) m_dummy_bad = 1;
                end else if (dq_out != 4'h0) m_dummy_bad = 1;
            end
            fl_xip = (m_conf == 1'b0);
            for (int n = 0; ; n++) begin
                @(negedge sck or posedge cs_n); #1;
                if (cs_n) break;
                if (dq_oe != 4'h0) m_rel_bad = 1;
                fl_d  = (n % 2 == 0) ? pat(m_addr + 24'(n / 2)) >> 4 : pat(m_addr + 24'(n / 2));
                fl_oe = 1'b1;
            end
            fl_oe = 1'b0;
        end
    end

    // received-byte monitor (R6)
    logic [23:0] exp_addr = '0;
    int rx_n = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            chk(rd_data == pat(exp_addr + 24'(rx_n)), "R6 data byte", rd_data, pat(exp_addr + 24'(rx_n)));
            rx_n++;
        end
    end

    // SCK phase width and idle level (R9), chip-select gap (R10)
    int hi_len = 0, gap_len = 0, idle_bad = 0;
    bit seen_cs = 0;
    logic sck_prev = 1'b0, cs_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sck) idle_bad++;
            if (req_ready && !cs_n) idle_bad++;
            if (sck) hi_len++;
            if (sck_prev && !sck) begin
                chk(hi_len == DIV, "R9 sck high width", hi_len, DIV);
                hi_len = 0;
            end
            if (cs_n) gap_len++;
            if (cs_prev && !cs_n) begin
                if (seen_cs) chk(gap_len >= 4 * DIV, "R10 chip select gap", gap_len, 4 * DIV);
                seen_cs = 1;
                gap_len = 0;
            end
            sck_prev = sck;
            cs_prev  = cs_n;
        end
    end

    bit xip_exp = 0;
    bit prev_exit = 0;

    task automatic do_txn(input logic [23:0] a, input logic [LW-1:0] l, input bit ex);
        bit want_cmd;
        want_cmd = !xip_exp;
        exp_addr = a;
        rx_n = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len_m1 = l; req_exit = ex;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        if (prev_exit)
            chk(m_had_cmd == 1, "R8 instruction resent after exit", m_had_cmd, 1);
        else if (want_cmd)
            chk(m_had_cmd == 1, "R1 instruction present", m_had_cmd, 1);
        else
            chk(m_had_cmd == 0, "R2 instruction skipped", m_had_cmd, 0);
        if (m_had_cmd) chk(m_cmd == 8'hEB, "R1 instruction byte", m_cmd, 8'hEB);
        chk(m_addr == a, "R3 address", m_addr, a);
        chk(!m_oe_bad, "R3 host-phase enables", m_oe_bad, 0);
        chk(m_conf == ex, "R4 confirmation bit", m_conf, ex);
        chk(!m_dummy_bad, "R4 dummy line values", m_dummy_bad, 0);
        chk(!m_rel_bad, "R5 bus released in data phase", m_rel_bad, 0);
        chk(rx_n == int'(l) + 1, "R6 byte count", rx_n, int'(l) + 1);
        xip_exp = !ex;
        chk(xip_active == xip_exp, "R7 xip flag", xip_active, xip_exp);
        prev_exit = ex;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (5) @(negedge clk);
        // R11
        chk(cs_n == 1, "R11 reset cs_n", cs_n, 1);
        chk(sck == 0, "R11 reset sck", sck, 0);
        chk(dq_oe == 0, "R11 reset dq_oe", dq_oe, 0);
        chk(req_ready == 1 && rd_valid == 0, "R11 reset ready/valid", {req_ready, rd_valid}, 2'b10);
        chk(xip_active == 0, "R11 reset xip", xip_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_txn(24'h000100, 8'd3, 1'b0);
        do_txn(24'h123456, 8'd0, 1'b0);
        do_txn(24'hFFFFFD, 8'd5, 1'b0);
        do_txn(24'hABCDEF, 8'd2, 1'b1);
        do_txn(24'h00F0F0, 8'd1, 1'b1);
        do_txn(24'h0A0B0C, 8'd4, 1'b0);
        for (int k = 0; k < 12; k++) begin
            logic [23:0] ra;
            logic [7:0]  rl;
            bit          re;
            ra = 24'($urandom);
            rl = 8'($urandom % 16);
            re = ($urandom % 4) == 0;
            do_txn(ra, rl, re);
        end
        do_txn(24'hFFFF80, 8'd255, 1'b0);
        do_txn(24'h555555, 8'd0, 1'b1);
        do_txn(24'h000000, 8'd0, 1'b0);
        repeat (20) @(negedge clk);
        chk(idle_bad == 0, "R9 sck low and ready only while deselected", idle_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule